// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst command into the column address of each beat of a memory burst. When a start strobe arrives it captures a start column, a length code and an ordering choice. From the next cycle on it presents one column per clock, together with a valid flag and a flag that marks the final beat. It drives a column address path and nothing else. Row, bank and data handling belong to other blocks.

Two orderings are supported. Sequential ordering counts upward and wraps inside the aligned window that the burst length defines. Interleaved ordering XORs the beat number into the low column bits. The full-page length walks the whole row and wraps from the top column to zero. It runs until a terminate request stops it or a new start replaces it. A new start is accepted on any cycle, including the final beat of a burst and the cycle right after a start.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `valid` = 0 and `last` = 0.
- R2: A `start` sampled high at an edge makes the next cycle show `valid` = 1 with `col` = `start_col` (beat 0). Each later cycle of the burst shows the next beat.
- R3: The `len_code` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. The values 4 to 7 select full page.
- R4: With `interleave` = 0 and a fixed length L, beat n shows the start column with its low log2(L) bits replaced by (start + n) mod L. The upper bits do not change.
- R5: With `interleave` = 1 and a fixed length L, beat n shows the start column with its low log2(L) bits XORed with n.
- R6: `last` is 1 exactly on beat L-1 of a fixed-length burst. In the cycle after that beat, `valid` is 0 unless a new start was sampled.
- R7: A full-page burst shows (start + n) mod 512 on beat n. It wraps from 511 to 0, keeps running, and never raises `last`.
- R8: `interleave` = 1 together with a full-page length code gives the same sequential full-page burst as `interleave` = 0.
- R9: A `stop` sampled high without `start` makes the next cycle show `valid` = 0. A `stop` while idle has no effect.
- R10: A `start` sampled during a burst replaces that burst at once: the next cycle shows beat 0 of the new burst. When `start` and `stop` are high together, `start` wins.
- R11: Changes to `start_col`, `len_code` or `interleave` while `start` is low do not alter a burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Burst command strobe, one cycle per burst |
| start_col | input | 9 | Column of beat 0 |
| len_code | input | 3 | Burst length selector (0:1, 1:2, 2:4, 3:8, 4-7: full page) |
| interleave | input | 1 | 1 selects XOR ordering, 0 selects wrapping increment |
| stop | input | 1 | Burst terminate request |
| col | output | 9 | Column address of the current beat |
| valid | output | 1 | A beat is being presented this cycle |
| last | output | 1 | The current beat is the final beat of a fixed-length burst |

## Verification
Every result of this block is due exactly one clock after the edge that samples its cause. Beat 0, the stop of a burst, the replacement by a new start and the drop of `valid` after the final beat all appear in the cycle that follows the triggering edge. Beat n then appears n cycles later. The driver predicts the outputs for the cycle after each edge it drives and queues that prediction. The monitor pops one entry per clock, two nanoseconds after the rising edge, so every comparison lands in the cycle where the change is due. While `valid` is 0 the monitor compares only `valid` and `last`.

// File: rtl/burst_col_pkg.sv
// Shared widths and the captured burst configuration.
// Assumes a power-of-two page of 2**COL_W columns and fixed bursts of at most 2**MAX_LOG beats.
package burst_col_pkg;
    localparam int COL_W   = 9;
    localparam int CODE_W  = 3;
    localparam int MAX_LOG = 3;

    typedef struct packed {
        logic [COL_W-1:0] base;   // column of beat 0
        logic [COL_W-1:0] mask;   // low bits that move; all ones for full page
        logic             full;   // full-page burst
        logic             xor_on; // interleaved ordering in force
    } burst_cfg_t;
endpackage

// File: rtl/burst_len_decode.sv
// Turns the length code into a window mask and a full-page flag.
// Codes 0..MAX_LOG give 2**code beats; larger codes mean full page, whose mask covers every column bit.
module burst_len_decode #(
    parameter int COL_W   = 9,
    parameter int CODE_W  = 3,
    parameter int MAX_LOG = 3
) (
    input  logic [CODE_W-1:0] code,
    output logic [COL_W-1:0]  mask,
    output logic              full
);
    assign full = (int'(code) > MAX_LOG);

    // One mask bit per column bit: set when it lies inside the burst window.
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask[i] = full || (int'(code) > i);
    end
endmodule

// File: rtl/burst_beat_counter.sv
// Tracks whether a burst is running and which beat is being presented.
// Assumes the mask is contiguous from bit 0; full-page bursts wrap the count and never end alone.
module burst_beat_counter #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] mask,
    input  logic             full,
    output logic             active,
    output logic [COL_W-1:0] cnt,
    output logic             last
);
    logic go_on;

    // Final beat of a fixed-length burst is reached when the count fills the window.
    assign last  = active && !full && (cnt == mask);
    assign go_on = active && !stop && !last;

    // Activity and beat count: start reloads, otherwise advance or drop out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else begin
            active <= go_on;
            cnt    <= go_on ? cnt + 1'b1 : cnt;
        end
    end

    p_last_needs_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> active);
    p_full_never_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && full) |-> !last);
    p_stop_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !active);
    p_start_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active && cnt == '0));
    p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !active);
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start && !stop && !last) |=> (active && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/burst_col_order.sv
// Maps the beat count onto a column with the captured ordering.
// Assumes xor_on is already cleared for full page, so full page always counts upward.
module burst_col_order #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] mask,
    input  logic             xor_on,
    input  logic [COL_W-1:0] cnt,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] xor_col;
    logic [COL_W-1:0] sum;

    assign sum     = base + cnt;
    assign seq_col = (base & ~mask) | (sum & mask);
    assign xor_col = base ^ (cnt & mask);

    // Pick the ordering captured at the start of the burst.
    always_comb begin
        col = xor_on ? xor_col : seq_col;
    end
endmodule

// File: rtl/burst_col_seq.sv
// Top of the burst column sequencer: captures a command on start and shows one column per beat.
// Assumes start is a one-cycle strobe; command inputs are ignored unless start is high.
module burst_col_seq
    import burst_col_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [CODE_W-1:0] len_code,
    input  logic              interleave,
    input  logic              stop,
    output logic [COL_W-1:0]  col,
    output logic              valid,
    output logic              last
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] cnt;
    logic             active;

    burst_len_decode #(.COL_W(COL_W), .CODE_W(CODE_W), .MAX_LOG(MAX_LOG)) u_dec (
        .code (len_code),
        .mask (dec_mask),
        .full (dec_full)
    );

    // Capture the command on start; interleave is dropped for full page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (start) begin
            cfg_q.base   <= start_col;
            cfg_q.mask   <= dec_mask;
            cfg_q.full   <= dec_full;
            cfg_q.xor_on <= interleave && !dec_full;
        end
    end

    burst_beat_counter #(.COL_W(COL_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .stop   (stop),
        .mask   (cfg_q.mask),
        .full   (cfg_q.full),
        .active (active),
        .cnt    (cnt),
        .last   (last)
    );

    burst_col_order #(.COL_W(COL_W)) u_ord (
        .base   (cfg_q.base),
        .mask   (cfg_q.mask),
        .xor_on (cfg_q.xor_on),
        .cnt    (cnt),
        .col    (col)
    );

    assign valid = active;

    p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (valid && col == $past(start_col)));
    p_window_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !start && !stop && !last) |=> ((col & ~cfg_q.mask) == $past(col & ~cfg_q.mask)));
    p_full_no_xor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && cfg_q.full) |-> !cfg_q.xor_on);
    p_hold_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(cfg_q));
endmodule

// File: tb/burst_col_seq_bench.sv
// Scoreboard bench: the driver predicts each cycle's outputs into a queue and the monitor compares them.
module burst_col_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       interleave = 1'b0;
    logic       stop = 1'b0;
    logic [8:0] col;
    logic       valid;
    logic       last;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit         v;
        bit [8:0]   c;
        bit         l;
        string      tag;
    } exp_t;
    exp_t q[$];

    // Reference state, built from the requirements.
    bit       m_act = 1'b0;
    bit [8:0] m_base = '0;
    int       m_cnt = 0;
    int       m_len = 1;   // 0 stands for full page
    bit       m_il = 1'b0;

    always #4 clk = ~clk;

    burst_col_seq u_burst_col_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_col  (start_col),
        .len_code   (len_code),
        .interleave (interleave),
        .stop       (stop),
        .col        (col),
        .valid      (valid),
        .last       (last)
    );

    function automatic bit m_last();
        return m_act && (m_len != 0) && (m_cnt == m_len - 1);
    endfunction

    function automatic bit [8:0] m_col();
        bit [8:0] msk;
        bit [8:0] n;
        n = 9'(m_cnt);
        if (m_len == 0) return m_base + n;
        msk = 9'(m_len - 1);
        if (m_il) return m_base ^ (n & msk);
        return (m_base & ~msk) | ((m_base + n) & msk);
    endfunction

    // Drive one cycle of inputs, advance the model across the coming edge, queue the prediction.
    task automatic drive(input bit s, input bit [8:0] c, input bit [2:0] code,
                         input bit t, input bit stp, input string tag);
        exp_t e;
        @(negedge clk);
        start = s; start_col = c; len_code = code; interleave = t; stop = stp;
        if (s) begin
            m_act = 1'b1; m_base = c; m_cnt = 0;
            m_len = (code > 3) ? 0 : (1 << code);
            m_il = t && (m_len != 0);
        end else if (m_act) begin
            if (stp || m_last()) m_act = 1'b0;
            else m_cnt = (m_cnt + 1) % 512;
        end
        e.v = m_act; e.c = m_col(); e.l = m_last(); e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) drive(0, 9'h0AA, 3'd5, 1'b1, 1'b0, tag);
    endtask

    // Monitor: one comparison per clock, 2 ns after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (valid !== e.v || last !== e.l || (e.v && col !== e.c)) begin
                    errors++;
                    $display("FAIL %s: got valid=%0b col=%0d last=%0b, expected valid=%0b col=%0d last=%0b",
                             e.tag, valid, col, last, e.v, e.c, e.l);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (valid !== 1'b0 || last !== 1'b0) begin
            errors++;
            $display("FAIL R1: got valid=%0b last=%0b, expected 0 0", valid, last);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R3 R4: sequential length 4 wrapping inside its window (13,14,15,12)
        drive(1, 9'd13, 3'd2, 1'b0, 1'b0, "R4");
        idle(5, "R6");
        // R5: interleaved length 8
        drive(1, 9'h1A5, 3'd3, 1'b1, 1'b0, "R5");
        idle(9, "R5");
        // R3 R6: single-beat burst, then interleaved length 2
        drive(1, 9'd77, 3'd0, 1'b0, 1'b0, "R6");
        drive(1, 9'd33, 3'd1, 1'b1, 1'b0, "R3");
        idle(3, "R6");
        // R7: full page wrapping past 511, then stopped (R9)
        drive(1, 9'd509, 3'd7, 1'b0, 1'b0, "R7");
        idle(6, "R7");
        drive(0, 9'd0, 3'd0, 1'b0, 1'b1, "R9");
        idle(2, "R9");
        // R8: interleave request with a full-page code
        drive(1, 9'd254, 3'd4, 1'b1, 1'b0, "R8");
        idle(4, "R8");
        drive(0, 9'd0, 3'd0, 1'b0, 1'b1, "R9");
        // R9: stop in the middle of a length-8 burst, and stop while idle
        drive(1, 9'd64, 3'd3, 1'b0, 1'b0, "R9");
        idle(2, "R9");
        drive(0, 9'd0, 3'd0, 1'b0, 1'b1, "R9");
        drive(0, 9'd0, 3'd0, 1'b0, 1'b1, "R9");
        idle(2, "R9");
        // R10: replacement mid-burst, start winning over stop, start on the final beat
        drive(1, 9'd200, 3'd3, 1'b0, 1'b0, "R10");
        idle(3, "R10");
        drive(1, 9'd7, 3'd2, 1'b1, 1'b0, "R10");
        drive(1, 9'd300, 3'd2, 1'b0, 1'b1, "R10");
        idle(3, "R10");
        drive(1, 9'd5, 3'd1, 1'b0, 1'b0, "R10");
        drive(1, 9'd6, 3'd1, 1'b0, 1'b0, "R10");
        idle(3, "R10");
        // R11: command inputs change while a burst runs
        drive(1, 9'd100, 3'd3, 1'b0, 1'b0, "R11");
        drive(0, 9'd3, 3'd0, 1'b1, 1'b0, "R11");
        drive(0, 9'd400, 3'd7, 1'b1, 1'b0, "R11");
        drive(0, 9'd1, 3'd1, 1'b0, 1'b0, "R11");
        idle(6, "R11");
        wait (q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule